// File: doc/BRIEF.md
# Sequential Signed Restoring Divider

This block divides one two's-complement integer by another over several clock cycles, with no conversion of the operands to magnitudes first. The divisor is kept in a register of its own. The dividend sits, sign-extended to twice the width, in a combined accumulator/quotient pair. Each iteration does four things in order:

- Shift the pair left by one bit.
- Add the divisor to the accumulator or subtract it, choosing by the signs of the partial remainder and the divisor.
- Keep the result if it stays on the dividend's side of zero, or restore the old accumulator if it does not.
- Record the outcome in the freed quotient bit.

After one iteration per quotient bit, a final cycle negates the quotient when the operand signs differ and publishes the results.

A client places both operands on the inputs and raises `start` while the block is idle. `busy` stays high while the division runs. A one-cycle `done` pulse marks the cycle in which quotient, remainder and the two exception flags become valid. The outputs then hold until the next `done`. A zero divisor is reported without iterating. The single quotient that cannot be represented, the most negative dividend divided by minus one, is flagged.

Top module: `signed_restoring_divider`

## Requirements
- R1: While reset is applied and in the first cycle after it, `busy`, `done`, `quotient`, `remainder`, `div_by_zero` and `overflow` are all 0.
- R2: For a nonzero divisor, and any operands other than the overflow pair, quotient × divisor + remainder equals the dividend, all taken as N-bit two's-complement values.
- R3: The quotient is truncated toward zero. The remainder is zero or carries the dividend's sign, and its magnitude is smaller than the divisor's. Examples: 7 / −3 gives −2 remainder 1, and −7 / 3 gives −2 remainder −1.
- R4: A start with a nonzero divisor is accepted when `busy` is low. `busy` then goes high from the next cycle for exactly N+1 cycles. `done` is high for one cycle, the first cycle in which `busy` is low again.
- R5: While `busy` is high, `start` and the operand inputs are ignored. The result and the busy length belong to the operands accepted first.
- R6: A start with a zero divisor raises `done` and `div_by_zero` in the next cycle, drives `quotient` and `remainder` to 0, and never raises `busy`.
- R7: The most negative dividend (only bit N−1 set) divided by −1 (all bits set) sets `overflow`. The quotient wraps to the most negative value and the remainder is 0.
- R8: `div_by_zero` and `overflow` are 0 in every `done` cycle of a division that is neither of the cases in R6 and R7.
- R9: `quotient`, `remainder` and both flags change only in a `done` cycle. A start raised in a `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a division; sampled only when idle |
| dividend | input | N | Signed dividend, sampled with start |
| divisor | input | N | Signed divisor, sampled with start |
| busy | output | 1 | High while a division is iterating or correcting |
| done | output | 1 | One-cycle pulse: results valid |
| quotient | output | N | Signed quotient, truncated toward zero |
| remainder | output | N | Signed remainder, sign of dividend |
| div_by_zero | output | 1 | The last division had a zero divisor |
| overflow | output | 1 | The last division was most-negative by −1 |

## Verification
The completion pulse of one division and the acceptance of the next can fall in the same cycle, because the block is already idle while `done` is high. The bench raises `start` with fresh operands in exactly the cycle that it sees `done` from the previous division. It then checks that the previous results were intact in that cycle, that the new division runs its full N+1 busy cycles, and that the new quotient and remainder match the reference computed from the new operands. A start raised in the middle of a busy period is checked in the same way: it must leave both the result and the busy length of the running division unchanged.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2
  } sdiv_state_e;
endpackage

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic divisor_zero,
  output logic load,
  output logic zero_hit,
  output logic iter_en,
  output logic fix_en,
  output logic busy
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  sdiv_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic          idle;

  assign idle     = (state_q == ST_IDLE);
  assign load     = start & idle & ~divisor_zero;
  assign zero_hit = start & idle & divisor_zero;
  assign iter_en  = (state_q == ST_ITER);
  assign fix_en   = (state_q == ST_FIX);
  assign busy     = ~idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (load) begin
            state_q <= ST_ITER;
            cnt_q   <= '0;
          end
        end
        ST_ITER: begin
          if (cnt_q == LAST) begin
            state_q <= ST_FIX;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
  parameter int N = 8
) (
  input  logic [N-1:0] acc,
  input  logic [N-1:0] quo,
  input  logic [N-1:0] dvs,
  input  logic         neg_dvd,
  input  logic [N-1:0] tail_mask,
  output logic [N-1:0] acc_next,
  output logic [N-1:0] quo_next
);
  logic [N-1:0] acc_sh;
  logic [N-1:0] quo_sh;
  logic [N-1:0] trial;
  logic         use_sub;
  logic         trial_zero;
  logic         tail_zero;
  logic         keep;

  // One iteration: shift the pair, then try to move the partial remainder toward zero.
  assign acc_sh  = {acc[N-2:0], quo[N-1]};
  assign quo_sh  = {quo[N-2:0], 1'b0};
  // The partial remainder's sign is taken as the dividend's, so a zero value
  // keeps the direction the dividend set.
  assign use_sub = (neg_dvd == dvs[N-1]);
  assign trial   = use_sub ? (acc_sh - dvs) : (acc_sh + dvs);

  assign trial_zero = (trial == '0);
  // Dividend bits not yet shifted into the accumulator.
  assign tail_zero  = ((quo_sh & tail_mask) == '0);

  always_comb begin
    if (neg_dvd) begin
      // A zero only counts when no lower dividend bits remain; those would make
      // the true partial remainder positive.
      keep = trial[N-1] | (trial_zero & tail_zero);
    end else begin
      keep = ~trial[N-1];
    end
  end

  assign acc_next = keep ? trial : acc_sh;
  assign quo_next = {quo_sh[N-1:1], keep};
endmodule

// File: rtl/sdiv_finish.sv
module sdiv_finish #(
  parameter int N = 8
) (
  input  logic [N-1:0] quo,
  input  logic [N-1:0] acc,
  input  logic         flip,
  output logic [N-1:0] quo_fixed,
  output logic [N-1:0] rem_fixed
);
  assign quo_fixed = flip ? (~quo + 1'b1) : quo;
  assign rem_fixed = acc;
endmodule

// File: rtl/signed_restoring_divider.sv
module signed_restoring_divider
  import sdiv_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder,
  output logic         div_by_zero,
  output logic         overflow
);
  localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] ALL_ONES = {N{1'b1}};

  logic         load;
  logic         zero_hit;
  logic         iter_en;
  logic         fix_en;

  logic [N-1:0] acc_q;
  logic [N-1:0] quo_q;
  logic [N-1:0] dvs_q;
  logic [N-1:0] mask_q;
  logic         neg_dvd_q;
  logic         flip_q;
  logic         ovf_pend_q;

  logic [N-1:0] acc_next;
  logic [N-1:0] quo_next;
  logic [N-1:0] quo_fixed;
  logic [N-1:0] rem_fixed;

  logic         done_q;
  logic [N-1:0] quot_q;
  logic [N-1:0] rem_q;
  logic         dbz_q;
  logic         ovf_q;

  sdiv_ctrl #(.N(N)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .divisor_zero (divisor == '0),
    .load         (load),
    .zero_hit     (zero_hit),
    .iter_en      (iter_en),
    .fix_en       (fix_en),
    .busy         (busy)
  );

  sdiv_step #(.N(N)) u_step (
    .acc       (acc_q),
    .quo       (quo_q),
    .dvs       (dvs_q),
    .neg_dvd   (neg_dvd_q),
    .tail_mask (mask_q),
    .acc_next  (acc_next),
    .quo_next  (quo_next)
  );

  sdiv_finish #(.N(N)) u_fin (
    .quo       (quo_q),
    .acc       (acc_q),
    .flip      (flip_q),
    .quo_fixed (quo_fixed),
    .rem_fixed (rem_fixed)
  );

  // Working registers: divisor, accumulator/quotient pair and bookkeeping of the run.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q      <= '0;
      quo_q      <= '0;
      dvs_q      <= '0;
      mask_q     <= '0;
      neg_dvd_q  <= 1'b0;
      flip_q     <= 1'b0;
      ovf_pend_q <= 1'b0;
    end else if (load) begin
      acc_q      <= {N{dividend[N-1]}};
      quo_q      <= dividend;
      dvs_q      <= divisor;
      mask_q     <= ALL_ONES << 1;
      neg_dvd_q  <= dividend[N-1];
      flip_q     <= dividend[N-1] ^ divisor[N-1];
      ovf_pend_q <= (dividend == MOST_NEG) && (divisor == ALL_ONES);
    end else if (iter_en) begin
      acc_q  <= acc_next;
      quo_q  <= quo_next;
      mask_q <= mask_q << 1;
    end
  end

  // Registered results, written only in the cycle that raises done.
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      quot_q <= '0;
      rem_q  <= '0;
      dbz_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      done_q <= fix_en | zero_hit;
      if (fix_en) begin
        quot_q <= quo_fixed;
        rem_q  <= rem_fixed;
        dbz_q  <= 1'b0;
        ovf_q  <= ovf_pend_q;
      end else if (zero_hit) begin
        quot_q <= '0;
        rem_q  <= '0;
        dbz_q  <= 1'b1;
        ovf_q  <= 1'b0;
      end
    end
  end

  assign done        = done_q;
  assign quotient    = quot_q;
  assign remainder   = rem_q;
  assign div_by_zero = dbz_q;
  assign overflow    = ovf_q;
endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [N-1:0] dividend,
  input logic [N-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] quotient,
  input logic [N-1:0] remainder,
  input logic         div_by_zero,
  input logic         overflow
);
  localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] ALL_ONES = {N{1'b1}};

  logic [N-1:0]          lat_dvd;
  logic [N-1:0]          lat_dvs;
  logic [31:0]           run_len;
  logic signed [2*N-1:0] recon;
  logic signed [2*N-1:0] dvd_wide;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_dvd <= '0;
      lat_dvs <= '0;
      run_len <= '0;
    end else begin
      if (start && !busy) begin
        lat_dvd <= dividend;
        lat_dvs <= divisor;
      end
      run_len <= busy ? run_len + 32'd1 : 32'd0;
    end
  end

  always_comb begin
    recon = $signed({{N{quotient[N-1]}}, quotient}) * $signed({{N{lat_dvs[N-1]}}, lat_dvs})
          + $signed({{N{remainder[N-1]}}, remainder});
    dvd_wide = $signed({{N{lat_dvd[N-1]}}, lat_dvd});
  end

  a_r2_identity: assert property (@(posedge clk) disable iff (rst)
    (done && !div_by_zero && !overflow) |-> (recon == dvd_wide));

  a_r4_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == N + 1));

  a_r4_done_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (done && !(start && divisor == '0)) |=> !done);

  a_r6_zero_divisor: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor == '0) |=> (done && div_by_zero && !busy
                                          && quotient == '0 && remainder == '0));

  a_r7_overflow_result: assert property (@(posedge clk) disable iff (rst)
    (done && overflow) |-> (quotient == MOST_NEG && remainder == '0));

  a_r8_no_spurious_flag: assert property (@(posedge clk) disable iff (rst)
    (done && lat_dvs != '0 && !(lat_dvd == MOST_NEG && lat_dvs == ALL_ONES))
      |-> (!overflow && !div_by_zero));

  a_r9_hold_results: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(remainder)
               && $stable(div_by_zero) && $stable(overflow)));
endmodule

bind signed_restoring_divider sdiv_checker #(.N(N)) u_sdiv_checker (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .dividend    (dividend),
  .divisor     (divisor),
  .busy        (busy),
  .done        (done),
  .quotient    (quotient),
  .remainder   (remainder),
  .div_by_zero (div_by_zero),
  .overflow    (overflow)
);

// File: tb/signed_restoring_divider_bench.sv
module signed_restoring_divider_bench;
  localparam int N    = 8;
  localparam int MINV = -(1 << (N - 1));
  localparam int MAXV = (1 << (N - 1)) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [N-1:0] dividend = '0;
  logic [N-1:0] divisor = '0;
  logic         busy;
  logic         done;
  logic [N-1:0] quotient;
  logic [N-1:0] remainder;
  logic         div_by_zero;
  logic         overflow;

  int tests = 0;
  int fails = 0;
  int busy_cnt;
  bit finished = 0;

  always #10 clk = ~clk;

  signed_restoring_divider #(.N(N)) u_signed_restoring_divider (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .dividend    (dividend),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .quotient    (quotient),
    .remainder   (remainder),
    .div_by_zero (div_by_zero),
    .overflow    (overflow)
  );

  function automatic int sx(input logic [N-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int exp_quot(input int a, input int b);
    if (b == 0) return 0;
    if (a == MINV && b == -1) return MINV;
    return a / b;
  endfunction

  function automatic int exp_rem(input int a, input int b);
    if (b == 0) return 0;
    if (a == MINV && b == -1) return 0;
    return a % b;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; drives start for one cycle and stops at the negedge where done is high.
  task automatic launch(input int a, input int b);
    int guard;
    start    = 1'b1;
    dividend = a[N-1:0];
    divisor  = b[N-1:0];
    @(negedge clk);
    start    = 1'b0;
    busy_cnt = 0;
    guard    = 0;
    while (!done && guard < 60) begin
      if (busy) busy_cnt++;
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic judge(input int a, input int b);
    int eq;
    int er;
    eq = exp_quot(a, b);
    er = exp_rem(a, b);
    chk("R4 done seen", int'(done), 1);
    chk("R3 quotient", sx(quotient), eq);
    chk("R3 remainder", sx(remainder), er);
    chk("R6 div_by_zero flag", int'(div_by_zero), (b == 0) ? 1 : 0);
    chk("R7/R8 overflow flag", int'(overflow), (a == MINV && b == -1) ? 1 : 0);
    chk("R4 busy cycles", busy_cnt, (b == 0) ? 0 : N + 1);
    if (b != 0 && !(a == MINV && b == -1))
      chk("R2 identity", sx(quotient) * b + sx(remainder), a);
  endtask

  task automatic run_op(input int a, input int b);
    @(negedge clk);
    launch(a, b);
    judge(a, b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int a;
    int b;
    int hq;
    int hr;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 quotient", sx(quotient), 0);
    chk("R1 remainder", sx(remainder), 0);
    chk("R1 flags", int'(div_by_zero) + int'(overflow), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 busy after reset", int'(busy), 0);

    // R3: the four sign combinations
    run_op(7, 3);
    run_op(7, -3);
    run_op(-7, 3);
    run_op(-7, -3);
    // corner cases for negative dividends and extremes
    run_op(-5, 1);
    run_op(-6, 3);
    run_op(0, -9);
    run_op(MINV, 1);
    run_op(MINV, 2);
    run_op(MAXV, -1);
    run_op(MAXV, MINV);
    run_op(MINV, MINV);
    run_op(3, 100);
    run_op(-3, 100);
    // R6: zero divisor
    run_op(45, 0);
    run_op(MINV, 0);
    // R7: the unrepresentable quotient
    run_op(MINV, -1);

    // R4: done lasts a single cycle
    run_op(100, 9);
    @(negedge clk);
    chk("R4 done single pulse", int'(done), 0);

    // R9: outputs hold while idle with changing inputs
    run_op(-100, 7);
    hq = sx(quotient);
    hr = sx(remainder);
    dividend = 8'h5A;
    divisor  = 8'h03;
    repeat (5) @(negedge clk);
    chk("R9 quotient held", sx(quotient), hq);
    chk("R9 remainder held", sx(remainder), hr);

    // R5: start during busy is ignored
    @(negedge clk);
    start    = 1'b1;
    dividend = 8'd100;
    divisor  = 8'd7;
    @(negedge clk);
    start    = 1'b0;
    busy_cnt = 1;
    repeat (3) @(negedge clk);
    busy_cnt += 3;
    start    = 1'b1;
    dividend = 8'hCE;
    divisor  = 8'h00;
    @(negedge clk);
    start    = 1'b0;
    busy_cnt++;
    while (!done && busy_cnt < 60) begin
      if (busy) busy_cnt++;
      @(negedge clk);
    end
    busy_cnt--; // the cycle of the first negedge was counted without busy check
    chk("R5 quotient of first operands", sx(quotient), 14);
    chk("R5 remainder of first operands", sx(remainder), 2);
    chk("R5 no zero flag", int'(div_by_zero), 0);
    chk("R5 busy length", busy_cnt, N + 1);

    // R9: start accepted in the done cycle (back-to-back)
    run_op(-77, 6);
    hq = sx(quotient);
    launch(50, -8);
    judge(50, -8);
    launch(-128, 5);
    judge(-128, 5);
    chk("R9 chained result differs from previous", int'(hq != sx(quotient)), 1);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      a = int'($urandom_range(0, 255)) - 128;
      case ($urandom_range(0, 9))
        0:       b = 0;
        1:       b = -1;
        2:       b = 1;
        3:       b = int'($urandom_range(0, 15)) - 8;
        default: b = int'($urandom_range(0, 255)) - 128;
      endcase
      if ($urandom_range(0, 19) == 0) a = MINV;
      run_op(a, b);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule